// File: doc/BRIEF.md
# Serial Divider-Ratio Programming Port

This block is the configuration front end of a frequency synthesizer. An outside controller drives three wires: a serial clock, a serial data line and a load strobe. Every rising serial clock edge moves one bit into a chain made of an 18-bit data register followed by a single control flag. The flag always holds the most recent bit. When the load strobe goes high, the flag picks which of two ratio registers is loaded from the data register. One is a 14-bit reference-divider ratio. The other is an 18-bit main-divider word, made of a 6-bit swallow count and a 12-bit program count.

The block runs on a fast system clock `clk`. The three serial wires go through a synchronizer in that domain, and edges are detected from the synchronized levels. All outputs come straight from flip-flops. A one-cycle update pulse reports which ratio register was loaded, and it fires when the load strobe returns low.

Top module: `synth_prog_port`

## Requirements
- R1: While `rst` is high at a `clk` edge, `ref_ratio`, `swallow_cnt`, `prog_cnt`, `ref_updated` and `main_updated` are all zero after that edge.
- R2: Each rising edge of `ser_clk` shifts `ser_data` into the chain, most significant bit first. A frame is 18 data bits followed by one control bit, and the control bit is the last bit sent.
- R3: With the control bit at 1, a high `ser_le` loads `ref_ratio` from data bits [13:0] and leaves `swallow_cnt` and `prog_cnt` unchanged.
- R4: With the control bit at 0, a high `ser_le` loads `swallow_cnt` from data bits [5:0] and `prog_cnt` from data bits [17:6], and leaves `ref_ratio` unchanged.
- R5: While `ser_le` is low, all three ratio outputs hold their values, even while frames are being shifted.
- R6: While `ser_le` is high, the selected register is transparent: it follows any further shifting.
- R7: Each falling edge of `ser_le` produces exactly one single-cycle pulse, on `ref_updated` if the control bit is 1 or on `main_updated` if it is 0. The two pulses never occur together.
- R8: Bits sent before the last 19 in a frame have no effect. Data bits [17:14] never reach `ref_ratio`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous to `clk` |
| ser_data | input | 1 | Serial data line |
| ser_le | input | 1 | Load strobe |
| ref_ratio | output | 14 | Reference-divider ratio |
| swallow_cnt | output | 6 | Swallow counter value of the main divider |
| prog_cnt | output | 12 | Program counter value of the main divider |
| ref_updated | output | 1 | Pulse: reference ratio was loaded |
| main_updated | output | 1 | Pulse: main-divider word was loaded |

## Verification
The assertions check the cycle-level rules on every cycle:
- the update pulses are exclusive and last one cycle;
- each register holds while the synchronized strobe is low;
- the unselected register stays still while the strobe is high;
- reset clears everything.

Bit ordering, the split of the main word into its two fields, and the discarding of surplus leading bits depend on whole serial frames. Only the bench's frame sweeps can show them, by comparing the outputs with values the bench computes itself. The same applies to transparency while the strobe is high.

// File: rtl/spp_pkg.sv
package spp_pkg;
  function automatic int unsigned wider(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  typedef enum logic {
    SEL_MAIN = 1'b0,
    SEL_REF  = 1'b1
  } sel_e;
endpackage

// File: rtl/spp_sync.sv
module spp_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign lvl = pipe[STAGES-1];
endmodule

// File: rtl/spp_shift.sv
module spp_shift #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] data_q,
  output logic         ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      ctrl_q <= 1'b0;
    end else if (shift_en) begin
      data_q <= {data_q[W-2:0], ctrl_q};
      ctrl_q <= din;
    end
  end
endmodule

// File: rtl/spp_latch.sv
module spp_latch #(
  parameter int unsigned W     = 14,
  parameter logic        SENSE = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         le_lvl,
  input  logic         le_fall,
  input  logic         ctrl,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         upd
);
  logic hit;
  assign hit = (ctrl == SENSE);

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= '0;
      upd <= 1'b0;
    end else begin
      if (le_lvl && hit) q <= d;
      upd <= le_fall && hit;
    end
  end
endmodule

// File: rtl/synth_prog_port.sv
module synth_prog_port #(
  parameter int unsigned REF_W       = 14,
  parameter int unsigned SWAL_W      = 6,
  parameter int unsigned PROG_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_le,
  output logic [REF_W-1:0]  ref_ratio,
  output logic [SWAL_W-1:0] swallow_cnt,
  output logic [PROG_W-1:0] prog_cnt,
  output logic              ref_updated,
  output logic              main_updated
);
  import spp_pkg::*;

  localparam int unsigned MAIN_W  = SWAL_W + PROG_W;
  localparam int unsigned SHIFT_W = wider(MAIN_W, REF_W);

  logic [2:0]         pins_sync;
  logic               sclk_prev, le_prev;
  logic               sclk_rise, le_fall, le_lvl;
  logic [SHIFT_W-1:0] shreg;
  logic               ctrl_bit;
  logic [MAIN_W-1:0]  main_word;

  spp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({ser_le, ser_data, ser_clk}),
    .lvl (pins_sync)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b0;
      le_prev   <= 1'b0;
    end else begin
      sclk_prev <= pins_sync[0];
      le_prev   <= pins_sync[2];
    end
  end

  assign sclk_rise = pins_sync[0] & ~sclk_prev;
  assign le_lvl    = pins_sync[2];
  assign le_fall   = le_prev & ~pins_sync[2];

  spp_shift #(.W(SHIFT_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (sclk_rise),
    .din      (pins_sync[1]),
    .data_q   (shreg),
    .ctrl_q   (ctrl_bit)
  );

  spp_latch #(.W(REF_W), .SENSE(SEL_REF)) u_ref (
    .clk     (clk),
    .rst     (rst),
    .le_lvl  (le_lvl),
    .le_fall (le_fall),
    .ctrl    (ctrl_bit),
    .d       (shreg[REF_W-1:0]),
    .q       (ref_ratio),
    .upd     (ref_updated)
  );

  spp_latch #(.W(MAIN_W), .SENSE(SEL_MAIN)) u_main (
    .clk     (clk),
    .rst     (rst),
    .le_lvl  (le_lvl),
    .le_fall (le_fall),
    .ctrl    (ctrl_bit),
    .d       (shreg[MAIN_W-1:0]),
    .q       (main_word),
    .upd     (main_updated)
  );

  assign swallow_cnt = main_word[SWAL_W-1:0];
  assign prog_cnt    = main_word[MAIN_W-1:SWAL_W];
endmodule

// File: rtl/spp_checker.sv
module spp_checker #(
  parameter int unsigned REF_W  = 14,
  parameter int unsigned SWAL_W = 6,
  parameter int unsigned PROG_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              le_lvl,
  input logic              ctrl_bit,
  input logic [REF_W-1:0]  ref_ratio,
  input logic [SWAL_W-1:0] swallow_cnt,
  input logic [PROG_W-1:0] prog_cnt,
  input logic              ref_updated,
  input logic              main_updated
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (ref_ratio == '0 && swallow_cnt == '0 && prog_cnt == '0 &&
             !ref_updated && !main_updated));

  // R7
  upd_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(ref_updated && main_updated));

  // R7
  ref_upd_single_chk: assert property (@(posedge clk) disable iff (rst)
    ref_updated |=> !ref_updated);

  // R7
  main_upd_single_chk: assert property (@(posedge clk) disable iff (rst)
    main_updated |=> !main_updated);

  // R5
  ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !le_lvl |=> $stable(ref_ratio));

  // R5
  main_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !le_lvl |=> ($stable(swallow_cnt) && $stable(prog_cnt)));

  // R3
  main_untouched_chk: assert property (@(posedge clk) disable iff (rst)
    (le_lvl && ctrl_bit) |=> ($stable(swallow_cnt) && $stable(prog_cnt)));

  // R4
  ref_untouched_chk: assert property (@(posedge clk) disable iff (rst)
    (le_lvl && !ctrl_bit) |=> $stable(ref_ratio));
endmodule

bind synth_prog_port spp_checker #(
  .REF_W(REF_W), .SWAL_W(SWAL_W), .PROG_W(PROG_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .le_lvl       (le_lvl),
  .ctrl_bit     (ctrl_bit),
  .ref_ratio    (ref_ratio),
  .swallow_cnt  (swallow_cnt),
  .prog_cnt     (prog_cnt),
  .ref_updated  (ref_updated),
  .main_updated (main_updated)
);

// File: tb/sim_synth_prog_port.sv
`timescale 1ns/1ps
module sim_synth_prog_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
  logic [13:0] ref_ratio;
  logic [5:0]  swallow_cnt;
  logic [11:0] prog_cnt;
  logic        ref_updated, main_updated;

  int n_chk = 0, n_fail = 0;
  int n_ref_pulse = 0, n_main_pulse = 0;
  bit done = 1'b0;

  logic [13:0] exp_ref  = '0;
  logic [5:0]  exp_swal = '0;
  logic [11:0] exp_prog = '0;
  int          exp_ref_n = 0, exp_main_n = 0;

  always #2.5 clk = ~clk;

  synth_prog_port u0 (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
    .ref_ratio(ref_ratio), .swallow_cnt(swallow_cnt), .prog_cnt(prog_cnt),
    .ref_updated(ref_updated), .main_updated(main_updated)
  );

  always @(negedge clk) begin
    if (ref_updated)  n_ref_pulse++;
    if (main_updated) n_main_pulse++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic gap();
    repeat (5) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_data = b; gap();
    ser_clk = 1'b1; gap();
    ser_clk = 1'b0; gap();
  endtask

  task automatic send_frame(input logic [17:0] d, input logic c);
    for (int i = 17; i >= 0; i--) send_bit(d[i]);
    send_bit(c);
  endtask

  task automatic strobe();
    ser_le = 1'b1; gap();
    ser_le = 1'b0; gap(); gap();
  endtask

  task automatic check_all(input string req);
    check({req, " ref"},  {18'd0, ref_ratio},   {18'd0, exp_ref});
    check({req, " swal"}, {26'd0, swallow_cnt}, {26'd0, exp_swal});
    check({req, " prog"}, {20'd0, prog_cnt},    {20'd0, exp_prog});
    check({req, " ref pulses"},  n_ref_pulse,  exp_ref_n);
    check({req, " main pulses"}, n_main_pulse, exp_main_n);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [17:0] w;
    repeat (4) @(negedge clk);
    rst = 1'b0; gap();
    // R1: reset state
    check_all("R1");

    // R4, R2: sweep every swallow value with a varying program value
    for (int s = 0; s < 64; s++) begin
      w = {12'((s * 67 + 5) % 4096), 6'(s)};
      send_frame(w, 1'b0);
      strobe();
      exp_swal = w[5:0]; exp_prog = w[17:6]; exp_main_n++;
      check_all("R4");
    end

    // R3, R8: reference sweep with junk in the upper data bits
    for (int r = 0; r < 64; r++) begin
      w = {4'(r ^ 4'hA), 14'((r * 257 + 3) % 16384)};
      send_frame(w, 1'b1);
      strobe();
      exp_ref = w[13:0]; exp_ref_n++;
      check_all("R3");
    end

    // R5: frame shifted without a strobe changes nothing
    send_frame(18'h2AAAA, 1'b0);
    check_all("R5");
    send_frame(18'h15555, 1'b1);
    check_all("R5");

    // R8: surplus leading bits are dropped
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    w = 18'h0C3A5;
    send_frame(w, 1'b0);
    strobe();
    exp_swal = w[5:0]; exp_prog = w[17:6]; exp_main_n++;
    check_all("R8");

    // R6: shifting while the strobe is high, the selected register follows
    w = 18'h01234;
    send_frame(w, 1'b1);
    ser_le = 1'b1; gap();
    send_bit(1'b1);
    ser_le = 1'b0; gap(); gap();
    exp_ref = {w[12:0], 1'b1}; exp_ref_n++;
    check_all("R6");

    // R7: strobe with nothing new gives one more pulse on the selected side only
    strobe();
    exp_ref_n++;
    check_all("R7");

    // R1: reset in the middle of operation
    rst = 1'b1; gap(); rst = 1'b0; gap();
    exp_ref = '0; exp_swal = '0; exp_prog = '0;
    check({"R1", " ref"},  {18'd0, ref_ratio},   32'd0);
    check({"R1", " swal"}, {26'd0, swallow_cnt}, 32'd0);
    check({"R1", " prog"}, {20'd0, prog_cnt},    32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule